// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Wake-Up Filter

This block receives asynchronous serial frames and delivers each byte into a holding register with status flags and interrupt requests. Every frame carries one extra mode bit after the data. A frame with this bit at 1 is an address frame and a frame with it at 0 is a data frame. This lets several receivers share one line while only the addressed one pays attention.

Software arms a wake-up filter with a set strobe. While the filter is armed and the address-frame mode is selected, data frames are thrown away silently. They are not loaded, they are not checked for errors, they raise no flag and they request no interrupt. The first address frame is delivered normally and disarms the filter in hardware. Software can also disarm it with a clear strobe.

Sampling uses a baud tick at sixteen times the bit rate. Each bit is taken at its midpoint. Status flags stay set until software clears them with dedicated strobes.

Top module: `mpwake_uart_rx`

## Requirements
- R1: After reset, `rx_data` is 0, all four flags are 0, `wake_armed` is 0, and both interrupt outputs are 0.
- R2: The frame format is as follows:
  - one low start bit;
  - eight data bits, LSB first;
  - one mode bit;
  - one high stop bit.
  Each bit lasts 16 `baud_tick` pulses and is sampled at its midpoint. A low pulse shorter than half a bit does not start a frame. A delivered frame loads `rx_data` and sets `full_flag`.
- R3: While `rx_en` is 0 no new frame starts. Lowering `rx_en` leaves every flag and `rx_data` unchanged.
- R4: A delivered frame whose stop bit samples low sets `ferr_flag`.
- R5: If a frame is delivered while `full_flag` is 1 and `clr_full` is not asserted in that cycle, `ovr_flag` is set and `rx_data` keeps its old value.
- R6: While filtering is active (`wake_armed`=1 and `mp_mode`=1), a frame with mode bit 0 changes none of `rx_data`, `full_flag`, `ferr_flag`, `ovr_flag` or `mpb_flag`.
- R7: While filtering is active, `rx_irq` and `err_irq` are 0 whatever the flags hold.
- R8: While filtering is active, a frame with mode bit 1 is delivered as in R2, sets `mpb_flag`, and clears `wake_armed` without any software action.
- R9: A `wake_clr` pulse clears `wake_armed` and so ends filtering. With `mp_mode`=0, an armed filter has no effect, and an address frame does not clear it.
- R10: Flags are cleared only by their clear strobes. A flag set by a frame in the same cycle as its clear strobe ends up 1. A `clr_full` that coincides with a delivery counts as consuming the old byte, so the new byte loads and no overrun occurs.
- R11: Outside filtering, the interrupt outputs behave as follows:
  - `rx_irq` = `full_flag` AND `rie`;
  - `err_irq` = (`ferr_flag` OR `ovr_flag`) AND `rie`.
- R12: With `mp_mode`=1, every delivered frame writes its mode bit into `mpb_flag`. With `mp_mode`=0, `mpb_flag` is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Allows new frames to start |
| mp_mode | input | 1 | Selects address/data frame interpretation |
| wake_set | input | 1 | Strobe that arms the wake-up filter |
| wake_clr | input | 1 | Strobe that disarms the wake-up filter |
| rie | input | 1 | Receive/error interrupt enable |
| clr_full | input | 1 | Clear strobe for full_flag |
| clr_ferr | input | 1 | Clear strobe for ferr_flag |
| clr_ovr | input | 1 | Clear strobe for ovr_flag |
| clr_mpb | input | 1 | Clear strobe for mpb_flag |
| rx_data | output | 8 | Received byte |
| full_flag | output | 1 | Unread byte present |
| ferr_flag | output | 1 | Framing error seen |
| ovr_flag | output | 1 | Overrun seen |
| mpb_flag | output | 1 | Mode bit of last delivered frame |
| wake_armed | output | 1 | Wake-up filter armed |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
A software clear of the full flag and the delivery of a new frame can fall in the same clock cycle. The bench provokes this by sending a byte that fills the register, then a second frame. During the second frame's stop bit it places a one-cycle `clr_full` at every offset from the first clock of that bit to the last. Each result must be one of two legal end states: the new byte loaded with no overrun, or the old byte kept with an overrun and the flag cleared. Across the sweep the outcome must switch exactly once, from the first state to the second.

// File: rtl/mpw_pkg.sv
package mpw_pkg;

    parameter int MPW_DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_MODE,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [MPW_DATA_W-1:0] data;
        logic                  mpb;
        logic                  stop_ok;
    } rx_frame_t;

    // A frame passes the wake-up filter unless filtering and it is a data frame.
    function automatic logic frame_passes(input logic filtering, input logic mpb);
        return !(filtering && !mpb);
    endfunction

    // Number of ticks from start detection to start-bit midpoint check, minus one.
    function automatic int mid_count(input int ovs);
        return ovs / 2 - 1;
    endfunction

endpackage

// File: rtl/mpw_line_sync.sv
module mpw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= {sr[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/mpw_frame_rx.sv
module mpw_frame_rx
    import mpw_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      line,
    input  logic      tick,
    input  logic      start_ok,
    output logic      done,
    output rx_frame_t frame,
    output logic      idle
);
    localparam int CW  = $clog2(OVS);
    localparam int IW  = $clog2(MPW_DATA_W);
    localparam int MID = mid_count(OVS);

    rx_state_e             state;
    logic [CW-1:0]         os_cnt;
    logic [IW-1:0]         bit_idx;
    logic [MPW_DATA_W-1:0] shreg;
    logic                  mode_bit;
    logic                  bit_end;

    assign bit_end = (os_cnt == CW'(OVS - 1));
    assign idle    = (state == RX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            os_cnt   <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            mode_bit <= 1'b0;
            done     <= 1'b0;
            frame    <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (start_ok && !line) begin
                            state  <= RX_START;
                            os_cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (os_cnt == CW'(MID)) begin
                            os_cnt  <= '0;
                            bit_idx <= '0;
                            state   <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (bit_end) begin
                            os_cnt <= '0;
                            shreg  <= {line, shreg[MPW_DATA_W-1:1]};
                            if (bit_idx == IW'(MPW_DATA_W - 1)) state <= RX_MODE;
                            else bit_idx <= bit_idx + 1'b1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_MODE: begin
                        if (bit_end) begin
                            os_cnt   <= '0;
                            mode_bit <= line;
                            state    <= RX_STOP;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (bit_end) begin
                            os_cnt <= '0;
                            frame  <= '{data: shreg, mpb: mode_bit, stop_ok: line};
                            done   <= 1'b1;
                            state  <= RX_IDLE;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpw_wake_gate.sv
module mpw_wake_gate (
    input  logic clk,
    input  logic rst,
    input  logic mp_mode,
    input  logic wake_set,
    input  logic wake_clr,
    input  logic frame_done,
    input  logic frame_mpb,
    output logic armed,
    output logic filtering
);
    logic addr_hit;

    assign filtering = armed && mp_mode;
    assign addr_hit  = filtering && frame_done && frame_mpb;

    always_ff @(posedge clk) begin
        if (rst)                        armed <= 1'b0;
        else if (wake_set)              armed <= 1'b1;
        else if (wake_clr || addr_hit)  armed <= 1'b0;
    end
endmodule

// File: rtl/mpw_rx_status.sv
module mpw_rx_status
    import mpw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_done,
    input  rx_frame_t             frame,
    input  logic                  filtering,
    input  logic                  mp_mode,
    input  logic                  rie,
    input  logic                  clr_full,
    input  logic                  clr_ferr,
    input  logic                  clr_ovr,
    input  logic                  clr_mpb,
    output logic [MPW_DATA_W-1:0] rx_data,
    output logic                  full_flag,
    output logic                  ferr_flag,
    output logic                  ovr_flag,
    output logic                  mpb_flag,
    output logic                  rx_irq,
    output logic                  err_irq
);
    logic accept;
    logic slot_free;

    assign accept    = frame_done && frame_passes(filtering, frame.mpb);
    assign slot_free = !full_flag || clr_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data   <= '0;
            full_flag <= 1'b0;
            ferr_flag <= 1'b0;
            ovr_flag  <= 1'b0;
            mpb_flag  <= 1'b0;
        end else begin
            if (accept && slot_free) rx_data <= frame.data;

            if (accept)        full_flag <= 1'b1;
            else if (clr_full) full_flag <= 1'b0;

            if (accept && !frame.stop_ok) ferr_flag <= 1'b1;
            else if (clr_ferr)            ferr_flag <= 1'b0;

            if (accept && !slot_free) ovr_flag <= 1'b1;
            else if (clr_ovr)         ovr_flag <= 1'b0;

            if (accept && mp_mode) mpb_flag <= frame.mpb;
            else if (clr_mpb)      mpb_flag <= 1'b0;
        end
    end

    assign rx_irq  = full_flag && rie && !filtering;
    assign err_irq = (ferr_flag || ovr_flag) && rie && !filtering;
endmodule

// File: rtl/mpwake_uart_rx.sv
module mpwake_uart_rx
    import mpw_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_line,
    input  logic                  baud_tick,
    input  logic                  rx_en,
    input  logic                  mp_mode,
    input  logic                  wake_set,
    input  logic                  wake_clr,
    input  logic                  rie,
    input  logic                  clr_full,
    input  logic                  clr_ferr,
    input  logic                  clr_ovr,
    input  logic                  clr_mpb,
    output logic [MPW_DATA_W-1:0] rx_data,
    output logic                  full_flag,
    output logic                  ferr_flag,
    output logic                  ovr_flag,
    output logic                  mpb_flag,
    output logic                  wake_armed,
    output logic                  rx_irq,
    output logic                  err_irq
);
    logic      line_s;
    logic      frame_done;
    rx_frame_t rx_frame;
    logic      rx_idle;
    logic      filtering;

    mpw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (line_s)
    );

    mpw_frame_rx #(.OVS(OVS)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .line     (line_s),
        .tick     (baud_tick),
        .start_ok (rx_en),
        .done     (frame_done),
        .frame    (rx_frame),
        .idle     (rx_idle)
    );

    mpw_wake_gate u_wake (
        .clk        (clk),
        .rst        (rst),
        .mp_mode    (mp_mode),
        .wake_set   (wake_set),
        .wake_clr   (wake_clr),
        .frame_done (frame_done),
        .frame_mpb  (rx_frame.mpb),
        .armed      (wake_armed),
        .filtering  (filtering)
    );

    mpw_rx_status u_status (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .frame      (rx_frame),
        .filtering  (filtering),
        .mp_mode    (mp_mode),
        .rie        (rie),
        .clr_full   (clr_full),
        .clr_ferr   (clr_ferr),
        .clr_ovr    (clr_ovr),
        .clr_mpb    (clr_mpb),
        .rx_data    (rx_data),
        .full_flag  (full_flag),
        .ferr_flag  (ferr_flag),
        .ovr_flag   (ovr_flag),
        .mpb_flag   (mpb_flag),
        .rx_irq     (rx_irq),
        .err_irq    (err_irq)
    );
endmodule

// File: rtl/mpwake_uart_rx_chk.sv
module mpwake_uart_rx_chk
    import mpw_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  rx_en,
    input logic                  wake_set,
    input logic                  clr_full,
    input logic                  clr_ferr,
    input logic                  clr_ovr,
    input logic                  clr_mpb,
    input logic [MPW_DATA_W-1:0] rx_data,
    input logic                  full_flag,
    input logic                  ferr_flag,
    input logic                  ovr_flag,
    input logic                  mpb_flag,
    input logic                  wake_armed,
    input logic                  rx_irq,
    input logic                  err_irq,
    input logic                  frame_done,
    input rx_frame_t             rx_frame,
    input logic                  rx_idle,
    input logic                  filtering
);
    logic clr_any;
    assign clr_any = clr_full || clr_ferr || clr_ovr || clr_mpb;

    // R3: no frame starts while receive is disabled
    a_r3_no_start: assert property (@(posedge clk) disable iff (rst)
        (rx_idle && !rx_en) |=> rx_idle);

    // R5: overrun keeps old byte and raises the overrun flag
    a_r5_overrun_keeps_data: assert property (@(posedge clk) disable iff (rst)
        (frame_done && full_flag && !clr_full && (!filtering || rx_frame.mpb))
        |=> ($stable(rx_data) && ovr_flag));

    // R6: a filtered data frame leaves data and flags alone
    a_r6_filtered_silent: assert property (@(posedge clk) disable iff (rst)
        (filtering && frame_done && !rx_frame.mpb && !clr_any)
        |=> $stable({rx_data, full_flag, ferr_flag, ovr_flag, mpb_flag}));

    // R7: interrupts held off while filtering
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
        filtering |-> (!rx_irq && !err_irq));

    // R8: address frame disarms filter and is delivered
    a_r8_addr_disarms: assert property (@(posedge clk) disable iff (rst)
        (filtering && frame_done && rx_frame.mpb && !wake_set)
        |=> (!wake_armed && full_flag && mpb_flag));

    // R10: without a frame or a clear strobe the flags hold
    a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (!frame_done && !clr_any)
        |=> $stable({full_flag, ferr_flag, ovr_flag, mpb_flag}));
endmodule

bind mpwake_uart_rx mpwake_uart_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .wake_set   (wake_set),
    .clr_full   (clr_full),
    .clr_ferr   (clr_ferr),
    .clr_ovr    (clr_ovr),
    .clr_mpb    (clr_mpb),
    .rx_data    (rx_data),
    .full_flag  (full_flag),
    .ferr_flag  (ferr_flag),
    .ovr_flag   (ovr_flag),
    .mpb_flag   (mpb_flag),
    .wake_armed (wake_armed),
    .rx_irq     (rx_irq),
    .err_irq    (err_irq),
    .frame_done (frame_done),
    .rx_frame   (rx_frame),
    .rx_idle    (rx_idle),
    .filtering  (filtering)
);

// File: tb/mpwake_uart_rx_bench.sv
module mpwake_uart_rx_bench;
    localparam int CPB = 32;   // clocks per bit: tick every 2 clocks, 16 ticks per bit
    localparam int GAP = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       baud_tick;
    logic       rx_en = 1'b0, mp_mode = 1'b0, wake_set = 1'b0, wake_clr = 1'b0, rie = 1'b0;
    logic       clr_full = 1'b0, clr_ferr = 1'b0, clr_ovr = 1'b0, clr_mpb = 1'b0;
    logic [7:0] rx_data;
    logic       full_flag, ferr_flag, ovr_flag, mpb_flag, wake_armed, rx_irq, err_irq;

    int total = 0;
    int bad   = 0;

    always @(posedge clk) begin
        if (rst) baud_tick <= 1'b0;
        else     baud_tick <= ~baud_tick;
    end

    mpwake_uart_rx u_mpwake_uart_rx (
        .clk(clk), .rst(rst), .rx_line(rx_line), .baud_tick(baud_tick),
        .rx_en(rx_en), .mp_mode(mp_mode), .wake_set(wake_set), .wake_clr(wake_clr),
        .rie(rie), .clr_full(clr_full), .clr_ferr(clr_ferr), .clr_ovr(clr_ovr),
        .clr_mpb(clr_mpb), .rx_data(rx_data), .full_flag(full_flag),
        .ferr_flag(ferr_flag), .ovr_flag(ovr_flag), .mpb_flag(mpb_flag),
        .wake_armed(wake_armed), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input int strobe_at);
        for (int i = 0; i < CPB; i++) begin
            @(negedge clk);
            rx_line  = v;
            clr_full = (i == strobe_at);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic m, input logic stp, input int strobe_at);
        drive_bit(1'b0, -1);
        for (int b = 0; b < 8; b++) drive_bit(d[b], -1);
        drive_bit(m, -1);
        drive_bit(stp, strobe_at);
        for (int i = 0; i < GAP; i++) begin
            @(negedge clk);
            rx_line  = 1'b1;
            clr_full = 1'b0;
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_full = 1; clr_ferr = 1; clr_ovr = 1; clr_mpb = 1;
        @(negedge clk);
        clr_full = 0; clr_ferr = 0; clr_ovr = 0; clr_mpb = 0;
    endtask

    task automatic pulse_wake(input logic set_not_clr);
        @(negedge clk);
        if (set_not_clr) wake_set = 1; else wake_clr = 1;
        @(negedge clk);
        wake_set = 0; wake_clr = 0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int switches;
        int first_loaded;
        int last_late;
        int prev_loaded;

        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 data", rx_data, 0);
        chk("R1 flags", {full_flag, ferr_flag, ovr_flag, mpb_flag}, 0);
        chk("R1 armed", wake_armed, 0);
        chk("R1 irqs", {rx_irq, err_irq}, 0);

        // R2 sweep over every byte value, mode bit toggled, non-address mode
        rx_en = 1; rie = 1;
        for (int d = 0; d < 256; d++) begin
            send(8'(d), d[0], 1'b1, -1);
            chk("R2 data", rx_data, d);
            chk("R2 full", full_flag, 1);
            chk("R11 rx_irq", rx_irq, 1);
            chk("R12 mpb untouched", mpb_flag, 0);
            clear_all();
        end

        // R2 short low glitch does not start a frame
        for (int i = 0; i < 6; i++) begin @(negedge clk); rx_line = 0; end
        for (int i = 0; i < 400; i++) begin @(negedge clk); rx_line = 1; end
        chk("R2 glitch full", full_flag, 0);

        // R4 framing error
        send(8'h3C, 1'b0, 1'b0, -1);
        chk("R4 ferr", ferr_flag, 1);
        chk("R4 data", rx_data, 8'h3C);
        chk("R11 err_irq", err_irq, 1);
        rie = 0;
        @(negedge clk);
        chk("R11 irqs masked by rie", {rx_irq, err_irq}, 0);
        rie = 1;

        // R3 disabling keeps flags and blocks reception
        rx_en = 0;
        repeat (20) @(negedge clk);
        chk("R3 flags kept", {full_flag, ferr_flag, ovr_flag}, 3'b110);
        send(8'h11, 1'b0, 1'b1, -1);
        chk("R3 no reception data", rx_data, 8'h3C);
        chk("R3 no reception ovr", ovr_flag, 0);
        rx_en = 1;
        clear_all();

        // R5 overrun
        send(8'hA1, 1'b0, 1'b1, -1);
        send(8'hB2, 1'b0, 1'b1, -1);
        chk("R5 ovr", ovr_flag, 1);
        chk("R5 data kept", rx_data, 8'hA1);
        chk("R11 err_irq ovr", err_irq, 1);
        clear_all();

        // R10 clear strobe swept across the completion cycle
        switches = 0; first_loaded = 0; last_late = 0; prev_loaded = 1;
        for (int k = 0; k < CPB; k++) begin
            logic loaded, late;
            clear_all();
            send(8'h40, 1'b0, 1'b1, -1);
            send(8'(8'h80 + k), 1'b0, 1'b1, k);
            loaded = full_flag && !ovr_flag && (rx_data == 8'(8'h80 + k));
            late   = !full_flag && ovr_flag && (rx_data == 8'h40);
            chk("R10 legal outcome", int'(loaded || late), 1);
            if (k == 0) first_loaded = int'(loaded);
            if (k == CPB - 1) last_late = int'(late);
            if (k > 0 && int'(loaded) != prev_loaded) switches++;
            prev_loaded = int'(loaded);
        end
        chk("R10 early strobe loads", first_loaded, 1);
        chk("R10 late strobe overruns", last_late, 1);
        chk("R10 single switch", switches, 1);
        clear_all();

        // R12 / R6 / R7 / R8 address mode
        mp_mode = 1;
        send(8'h21, 1'b0, 1'b1, -1);
        chk("R12 mpb written 0", mpb_flag, 0);
        chk("R11 rx_irq mp", rx_irq, 1);
        pulse_wake(1'b1);
        chk("R9 armed", wake_armed, 1);
        chk("R7 rx_irq held off", rx_irq, 0);
        chk("R7 full still set", full_flag, 1);
        send(8'h22, 1'b0, 1'b1, -1);
        chk("R6 no overrun", ovr_flag, 0);
        chk("R6 data kept", rx_data, 8'h21);
        clear_all();
        send(8'h33, 1'b0, 1'b0, -1);
        chk("R6 filtered flags", {full_flag, ferr_flag, ovr_flag, mpb_flag}, 0);
        chk("R6 data unchanged", rx_data, 8'h21);
        chk("R7 irqs", {rx_irq, err_irq}, 0);
        chk("R6 still armed", wake_armed, 1);
        send(8'h5A, 1'b1, 1'b1, -1);
        chk("R8 data", rx_data, 8'h5A);
        chk("R8 full", full_flag, 1);
        chk("R8 mpb", mpb_flag, 1);
        chk("R8 disarmed", wake_armed, 0);
        chk("R8 rx_irq", rx_irq, 1);
        @(negedge clk); clr_full = 1; @(negedge clk); clr_full = 0;
        send(8'h5B, 1'b0, 1'b1, -1);
        chk("R12 mpb written back 0", mpb_flag, 0);
        chk("R12 data", rx_data, 8'h5B);
        clear_all();

        // R9 software disarm, and no effect outside address mode
        pulse_wake(1'b1);
        pulse_wake(1'b0);
        chk("R9 disarmed", wake_armed, 0);
        send(8'h66, 1'b0, 1'b1, -1);
        chk("R9 delivered after clear", rx_data, 8'h66);
        clear_all();
        mp_mode = 0;
        pulse_wake(1'b1);
        send(8'h77, 1'b1, 1'b1, -1);
        chk("R9 delivered when not mp", rx_data, 8'h77);
        chk("R9 irq when not mp", rx_irq, 1);
        chk("R9 stays armed", wake_armed, 1);
        chk("R12 mpb untouched not mp", mpb_flag, 0);

        finish_run();
    end
endmodule